// File: doc/BRIEF.md
# Multi-Way Translation Lookup with Ring Resolution

This block searches every way of a translation buffer for one 32-bit virtual address. Each way works out its own page mask and entry index from the address (and, for the large-page ways, from a page-size configuration word). It then compares the selected entry's stored page number against the masked address. An entry counts as a hit only if its address-space identifier is nonzero and matches one of the four identifier bytes held in the ring register. The lowest matching byte position gives the access ring.

The search is combinational. The result is registered one cycle after a request. A single hit reports the way, the entry index and the ring. No hit, or more than one hit, produces a fault cause code, with separate codes for instruction and data lookups. The block also produces a probe word that software can read. It is nonzero only for a single hit whose ring is at or above the current privilege ring.

The entry storage is supplied as flat input arrays, one slot per way and entry. Slot `w*WAY_ENTRIES + e` holds entry `e` of way `w`. Refill and attribute decoding are outside this block.

Top module: `tlbl_lookup`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was sampled high. All other outputs change only on such a request and otherwise hold their values.
- R2: A way hits only when its selected entry's page number equals the address ANDed with that way's page mask, and the entry's identifier is nonzero. An identifier of zero or a page mismatch gives no hit.
- R3: The ring is the lowest byte position i (0..3) such that byte i (bits 8i+7:8i) of `ring_asid` equals the entry's identifier. An entry whose identifier is in no byte is not a hit.
- R4: With exactly one hitting way, `rsp_hit`=1, `rsp_cause`=0, and `rsp_way`, `rsp_idx` and `rsp_ring` give that way, its entry index and its ring.
- R5: With no hitting way, `rsp_hit`=0 and `rsp_cause` is 16 for an instruction lookup (`req_is_data`=0) or 24 for a data lookup.
- R6: With two or more hitting ways, `rsp_hit`=0 and `rsp_cause` is 17 for an instruction lookup or 25 for a data lookup. No way is chosen.
- R7: When there is a single hit whose ring is >= `req_ring`, `rsp_probe` = (address AND 0xFFFFF000) OR way OR (0x10 for data, 0x08 for instruction). In every other case it is 0.
- R8: Ways 0..3 use 4 KiB pages (mask 0xFFFFF000). Their entry index is log2(REFILL_ENTRIES) address bits starting at bit 12.
- R9: Way 4 takes its size s from `size_cfg[17:16]`. Its mask is 0xFFF00000 << 2s, and its index is the 2 address bits starting at bit 20+2s.
- R10: When VAR_WAY56=0, way 5 has mask 0xF8000000 and index bit 27, and way 6 has mask 0xF0000000 and index bit 28. Bits 20 and 24 of `size_cfg` have no effect.
- R11: When VAR_WAY56=1, way 5 takes s=`size_cfg[20]`, mask 0xF8000000<<s and a 2-bit index starting at bit 27+s. Way 6 takes s=`size_cfg[24]`, mask 0xF0000000<<(1-s) and a 3-bit index starting at bit 29-s.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_is_data | input | 1 | 1 = data lookup, 0 = instruction lookup |
| req_ring | input | RING_W | Current privilege ring used by the probe |
| ring_asid | input | RING_COUNT*ASID_W | Identifier byte for each ring, ring 0 in the low byte |
| size_cfg | input | 32 | Page-size configuration word for ways 4..6 |
| ent_vpn | input | NUM_WAYS*WAY_ENTRIES*32 | Stored page numbers, one per slot |
| ent_asid | input | NUM_WAYS*WAY_ENTRIES*ASID_W | Stored identifiers, one per slot |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Exactly one way hit |
| rsp_way | output | WAY_W | Hitting way |
| rsp_idx | output | IDX_W | Entry index within the hitting way |
| rsp_ring | output | RING_W | Ring of the hitting entry |
| rsp_cause | output | 6 | 0, or the miss or multi-hit fault code |
| rsp_probe | output | 32 | Probe word for software |

## Verification
The hardest condition to reach is a multi-hit. Two ways of different geometry must select entries holding the same masked page and a recognised identifier in the same lookup. The bench loads two of the 4 KiB ways with identical entries at the same index to force it. The variable-size ways need a different size word for the same address to move the selected entry. The bench covers this with a second instance built with variable sizing. It sweeps the size bits so that one address lands in different slots, while the fixed instance, given the same inputs, must not change.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
   localparam int VA_W    = 32;
   localparam int CAUSE_W = 6;
   typedef logic [CAUSE_W-1:0] cause_t;

   localparam cause_t CAUSE_OK      = 6'd0;
   localparam cause_t CAUSE_I_MISS  = 6'd16;
   localparam cause_t CAUSE_I_MULTI = 6'd17;
   localparam cause_t CAUSE_D_MISS  = 6'd24;
   localparam cause_t CAUSE_D_MULTI = 6'd25;
endpackage

// File: rtl/tlbl_way_geom.sv
// Page mask and entry index for one way; the way number picks the variant.
module tlbl_way_geom #(
   parameter int WAY            = 0,
   parameter bit VAR_WAY56      = 1'b0,
   parameter int REFILL_ENTRIES = 4,
   parameter int IDX_W          = 3
) (
   input  logic [31:0]      vaddr,
   input  logic [31:0]      size_cfg,
   output logic [31:0]      page_mask,
   output logic [IDX_W-1:0] entry_idx
);
   localparam int REF_BITS = (REFILL_ENTRIES > 1) ? $clog2(REFILL_ENTRIES) : 1;

   logic [31:0] idx_full;

   generate
      if (WAY < 4) begin : g_refill
         assign page_mask = 32'hFFFF_F000;
         assign idx_full  = (vaddr >> 12) & ((32'd1 << REF_BITS) - 32'd1);
      end else if (WAY == 4) begin : g_way4
         logic [1:0] sz;
         assign sz        = size_cfg[17:16];
         assign page_mask = 32'hFFF0_0000 << {sz, 1'b0};
         assign idx_full  = (vaddr >> (5'd20 + {2'b00, sz, 1'b0})) & 32'd3;
      end else if (WAY == 5 && VAR_WAY56) begin : g_way5_var
         logic sz;
         assign sz        = size_cfg[20];
         assign page_mask = 32'hF800_0000 << sz;
         assign idx_full  = (vaddr >> (5'd27 + {4'b0000, sz})) & 32'd3;
      end else if (WAY == 5) begin : g_way5_fix
         assign page_mask = 32'hF800_0000;
         assign idx_full  = {31'd0, vaddr[27]};
      end else if (WAY == 6 && VAR_WAY56) begin : g_way6_var
         logic sz;
         assign sz        = size_cfg[24];
         assign page_mask = 32'hF000_0000 << (~sz);
         assign idx_full  = (vaddr >> (5'd29 - {4'b0000, sz})) & 32'd7;
      end else if (WAY == 6) begin : g_way6_fix
         assign page_mask = 32'hF000_0000;
         assign idx_full  = {31'd0, vaddr[28]};
      end else begin : g_plain
         assign page_mask = 32'hFFFF_F000;
         assign idx_full  = 32'd0;
      end
   endgenerate

   assign entry_idx = idx_full[IDX_W-1:0];

   logic unused_geom;
   assign unused_geom = ^{size_cfg, vaddr, idx_full};
endmodule

// File: rtl/tlbl_ring_find.sv
// Lowest ring whose identifier byte equals the given identifier.
module tlbl_ring_find #(
   parameter int RING_COUNT = 4,
   parameter int ASID_W     = 8,
   parameter int RING_W     = 2
) (
   input  logic [ASID_W-1:0]            asid,
   input  logic [RING_COUNT*ASID_W-1:0] ring_asid,
   output logic                         found,
   output logic [RING_W-1:0]            ring
);
   always_comb begin
      found = 1'b0;
      ring  = '0;
      for (int i = RING_COUNT - 1; i >= 0; i--) begin
         if (ring_asid[i*ASID_W +: ASID_W] == asid) begin
            found = 1'b1;
            ring  = RING_W'(i);
         end
      end
   end
endmodule

// File: rtl/tlbl_lookup.sv
module tlbl_lookup
   import tlbl_pkg::*;
#(
   parameter int NUM_WAYS       = 7,
   parameter int WAY_ENTRIES    = 8,
   parameter int REFILL_ENTRIES = 4,
   parameter bit VAR_WAY56      = 1'b0,
   parameter int RING_COUNT     = 4,
   parameter int ASID_W         = 8,
   localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
   localparam int IDX_W  = (WAY_ENTRIES > 1) ? $clog2(WAY_ENTRIES) : 1,
   localparam int RING_W = (RING_COUNT > 1) ? $clog2(RING_COUNT) : 1,
   localparam int SLOTS  = NUM_WAYS * WAY_ENTRIES
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [31:0]                  req_vaddr,
   input  logic                         req_is_data,
   input  logic [RING_W-1:0]            req_ring,
   input  logic [RING_COUNT*ASID_W-1:0] ring_asid,
   input  logic [31:0]                  size_cfg,
   input  logic [SLOTS*32-1:0]          ent_vpn,
   input  logic [SLOTS*ASID_W-1:0]      ent_asid,
   output logic                         rsp_valid,
   output logic                         rsp_hit,
   output logic [WAY_W-1:0]             rsp_way,
   output logic [IDX_W-1:0]             rsp_idx,
   output logic [RING_W-1:0]            rsp_ring,
   output logic [CAUSE_W-1:0]           rsp_cause,
   output logic [31:0]                  rsp_probe
);
   // elaboration-time parameter checks
   generate
      if (NUM_WAYS < 1 || NUM_WAYS > 8) begin : g_chk_ways
         $error("tlbl_lookup: NUM_WAYS must be 1..8 so the way fits below the probe flag bits");
      end
      if ((WAY_ENTRIES & (WAY_ENTRIES - 1)) != 0 || WAY_ENTRIES < REFILL_ENTRIES) begin : g_chk_ent
         $error("tlbl_lookup: WAY_ENTRIES must be a power of two covering REFILL_ENTRIES");
      end
      if (NUM_WAYS > 4 && WAY_ENTRIES < 4) begin : g_chk_w4
         $error("tlbl_lookup: way 4 needs at least 4 entries");
      end
      if (VAR_WAY56 && NUM_WAYS > 6 && WAY_ENTRIES < 8) begin : g_chk_w6
         $error("tlbl_lookup: variable way 6 needs at least 8 entries");
      end
      if (RING_COUNT < 1 || ASID_W < 1) begin : g_chk_ring
         $error("tlbl_lookup: RING_COUNT and ASID_W must be positive");
      end
   endgenerate

   logic [NUM_WAYS-1:0] way_hit;
   logic [IDX_W-1:0]    way_idx  [NUM_WAYS];
   logic [RING_W-1:0]   way_ring [NUM_WAYS];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic [31:0]       mask;
      logic [IDX_W-1:0]  idx;
      logic [31:0]       slot;
      logic [31:0]       sel_vpn;
      logic [ASID_W-1:0] sel_asid;
      logic              ring_ok;
      logic [RING_W-1:0] ring;

      tlbl_way_geom #(
         .WAY(w), .VAR_WAY56(VAR_WAY56),
         .REFILL_ENTRIES(REFILL_ENTRIES), .IDX_W(IDX_W)
      ) u_geom (
         .vaddr(req_vaddr), .size_cfg(size_cfg),
         .page_mask(mask), .entry_idx(idx)
      );

      assign slot     = 32'(w * WAY_ENTRIES) + 32'(idx);
      assign sel_vpn  = ent_vpn[slot*32 +: 32];
      assign sel_asid = ent_asid[slot*ASID_W +: ASID_W];

      tlbl_ring_find #(
         .RING_COUNT(RING_COUNT), .ASID_W(ASID_W), .RING_W(RING_W)
      ) u_ring (
         .asid(sel_asid), .ring_asid(ring_asid),
         .found(ring_ok), .ring(ring)
      );

      assign way_hit[w]  = ((req_vaddr & mask) == sel_vpn) && (sel_asid != '0) && ring_ok;
      assign way_idx[w]  = idx;
      assign way_ring[w] = ring;
   end

   // merge the per-way results
   logic              single;
   logic              none;
   logic [WAY_W-1:0]  pick_way;
   logic [IDX_W-1:0]  pick_idx;
   logic [RING_W-1:0] pick_ring;
   cause_t            next_cause;
   logic [31:0]       next_probe;

   always_comb begin
      pick_way  = '0;
      pick_idx  = '0;
      pick_ring = '0;
      for (int w = 0; w < NUM_WAYS; w++) begin
         if (way_hit[w]) begin
            pick_way  = WAY_W'(w);
            pick_idx  = way_idx[w];
            pick_ring = way_ring[w];
         end
      end
   end

   assign single = ($countones(way_hit) == 1);
   assign none   = (way_hit == '0);

   always_comb begin
      if (single)     next_cause = CAUSE_OK;
      else if (none)  next_cause = req_is_data ? CAUSE_D_MISS  : CAUSE_I_MISS;
      else            next_cause = req_is_data ? CAUSE_D_MULTI : CAUSE_I_MULTI;
   end

   always_comb begin
      next_probe = '0;
      if (single && (pick_ring >= req_ring)) begin
         next_probe = {req_vaddr[31:12], 12'h000} | 32'(pick_way) |
                      (req_is_data ? 32'h0000_0010 : 32'h0000_0008);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_way   <= '0;
         rsp_idx   <= '0;
         rsp_ring  <= '0;
         rsp_cause <= CAUSE_OK;
         rsp_probe <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_hit   <= single;
            rsp_way   <= single ? pick_way  : '0;
            rsp_idx   <= single ? pick_idx  : '0;
            rsp_ring  <= single ? pick_ring : '0;
            rsp_cause <= next_cause;
            rsp_probe <= next_probe;
         end
      end
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid)); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(rsp_probe) && $stable(rsp_cause) && $stable(rsp_way))); // R1
   AST_HIT_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_cause == CAUSE_OK)); // R4
   AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_cause == CAUSE_I_MISS || rsp_cause == CAUSE_D_MISS ||
                                   rsp_cause == CAUSE_I_MULTI || rsp_cause == CAUSE_D_MULTI)); // R6
   AST_FAULT_NO_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_probe == 32'd0)); // R5
   AST_PROBE_RING: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_probe != 32'd0) |-> (rsp_hit && rsp_ring >= $past(req_ring))); // R7
   AST_PROBE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_probe != 32'd0) |-> ($countones(rsp_probe[4:3]) == 1)); // R7
endmodule

// File: tb/tlbl_lookup_test.sv
`timescale 1ns/1ps
module tlbl_lookup_test;
   localparam int NW = 7;
   localparam int NE = 8;
   localparam int SL = NW * NE;

   typedef struct packed {
      logic [31:0] va;
      logic        dat;
      logic [1:0]  rg;
      logic        hit;
      logic [2:0]  way;
      logic [2:0]  idx;
      logic [1:0]  ring;
      logic [5:0]  cause;
      logic [31:0] probe;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t TBL [NV] = '{
      '{32'h00013000, 1'b0, 2'd0, 1'b1, 3'd1, 3'd3, 2'd0, 6'd0,  32'h00013009}, // R4 R8
      '{32'h00013000, 1'b1, 2'd0, 1'b1, 3'd1, 3'd3, 2'd0, 6'd0,  32'h00013011}, // R7 data flag
      '{32'h00025000, 1'b0, 2'd3, 1'b1, 3'd2, 3'd1, 2'd2, 6'd0,  32'h00000000}, // R7 ring below
      '{32'h00025000, 1'b0, 2'd2, 1'b1, 3'd2, 3'd1, 2'd2, 6'd0,  32'h0002500A}, // R7 ring equal
      '{32'h00046000, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 6'd17, 32'h00000000}, // R6 instr
      '{32'h00046000, 1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 6'd25, 32'h00000000}, // R6 data
      '{32'h00057000, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 6'd16, 32'h00000000}, // R3 no ring
      '{32'h00060000, 1'b1, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 6'd24, 32'h00000000}, // R2 R5 zero id
      '{32'h12300ABC, 1'b1, 2'd0, 1'b1, 3'd4, 3'd3, 2'd3, 6'd0,  32'h12300014}, // R9
      '{32'hD0001234, 1'b0, 2'd0, 1'b1, 3'd5, 3'd0, 2'd0, 6'd0,  32'hD000100D}, // R10 way 5
      '{32'hF0000010, 1'b1, 2'd1, 1'b1, 3'd6, 3'd1, 2'd0, 6'd0,  32'h00000000}, // R10 way 6
      '{32'h00017000, 1'b0, 2'd0, 1'b0, 3'd0, 3'd0, 2'd0, 6'd16, 32'h00000000}  // R2 R5 page mismatch
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_is_data = 1'b0;
   logic [1:0]  req_ring = '0;
   logic [31:0] ring_asid = 32'h04030201;
   logic [31:0] size_cfg = '0;
   logic [SL*32-1:0] ent_vpn;
   logic [SL*8-1:0]  ent_asid;

   logic [31:0] tvpn  [NW][NE];
   logic [7:0]  tasid [NW][NE];

   always_comb begin
      for (int w = 0; w < NW; w++)
         for (int e = 0; e < NE; e++) begin
            ent_vpn[(w*NE+e)*32 +: 32] = tvpn[w][e];
            ent_asid[(w*NE+e)*8 +: 8]  = tasid[w][e];
         end
   end

   logic        v_valid, v_hit;
   logic [2:0]  v_way, v_idx;
   logic [1:0]  v_ring;
   logic [5:0]  v_cause;
   logic [31:0] v_probe;
   logic        x_valid, x_hit;
   logic [2:0]  x_way, x_idx;
   logic [1:0]  x_ring;
   logic [5:0]  x_cause;
   logic [31:0] x_probe;

   tlbl_lookup #(.NUM_WAYS(NW), .WAY_ENTRIES(NE), .REFILL_ENTRIES(4), .VAR_WAY56(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_is_data(req_is_data), .req_ring(req_ring), .ring_asid(ring_asid),
      .size_cfg(size_cfg), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .rsp_valid(v_valid), .rsp_hit(v_hit), .rsp_way(v_way), .rsp_idx(v_idx),
      .rsp_ring(v_ring), .rsp_cause(v_cause), .rsp_probe(v_probe));

   tlbl_lookup #(.NUM_WAYS(NW), .WAY_ENTRIES(NE), .REFILL_ENTRIES(4), .VAR_WAY56(1'b1)) uut_var (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_is_data(req_is_data), .req_ring(req_ring), .ring_asid(ring_asid),
      .size_cfg(size_cfg), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
      .rsp_valid(x_valid), .rsp_hit(x_hit), .rsp_way(x_way), .rsp_idx(x_idx),
      .rsp_ring(x_ring), .rsp_cause(x_cause), .rsp_probe(x_probe));

   always #10 clk = ~clk; // 50 MHz

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic look(input logic [31:0] va, input logic dat, input logic [1:0] rg);
      @(negedge clk);
      req_vaddr = va; req_is_data = dat; req_ring = rg; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int w = 0; w < NW; w++)
         for (int e = 0; e < NE; e++) begin
            tvpn[w][e] = '0; tasid[w][e] = '0;
         end
      tvpn[1][3] = 32'h00013000; tasid[1][3] = 8'h01;
      tvpn[2][1] = 32'h00025000; tasid[2][1] = 8'h03;
      tvpn[0][2] = 32'h00046000; tasid[0][2] = 8'h02;
      tvpn[3][2] = 32'h00046000; tasid[3][2] = 8'h02;
      tvpn[0][3] = 32'h00057000; tasid[0][3] = 8'h55;
      tvpn[0][0] = 32'h00060000; tasid[0][0] = 8'h00;
      tvpn[4][3] = 32'h12300000; tasid[4][3] = 8'h04;
      tvpn[4][1] = 32'h12400000; tasid[4][1] = 8'h01;
      tvpn[5][0] = 32'hD0000000; tasid[5][0] = 8'h01;
      tvpn[5][2] = 32'hD0000000; tasid[5][2] = 8'h02;
      tvpn[6][1] = 32'hF0000000; tasid[6][1] = 8'h01;
      tvpn[6][7] = 32'hE0000000; tasid[6][7] = 8'h01;
      tvpn[6][5] = 32'hD0000000; tasid[6][5] = 8'h01;

      // reset state, with a request pending
      req_valid = 1'b1; req_vaddr = 32'h00013000;
      repeat (3) @(negedge clk);
      chk("R12 valid in reset", 32'(v_valid), 32'd0);
      chk("R12 probe in reset", v_probe, 32'd0);
      chk("R12 cause in reset", 32'(v_cause), 32'd0);
      req_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 no response without request", 32'(v_valid), 32'd0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         look(TBL[i].va, TBL[i].dat, TBL[i].rg);
         chk($sformatf("R1 valid row %0d", i), 32'(v_valid), 32'd1);
         chk($sformatf("R4 hit row %0d", i), 32'(v_hit), 32'(TBL[i].hit));
         chk($sformatf("R5 R6 cause row %0d", i), 32'(v_cause), 32'(TBL[i].cause));
         chk($sformatf("R7 probe row %0d", i), v_probe, TBL[i].probe);
         if (TBL[i].hit) begin
            chk($sformatf("R4 way row %0d", i), 32'(v_way), 32'(TBL[i].way));
            chk($sformatf("R4 idx row %0d", i), 32'(v_idx), 32'(TBL[i].idx));
            chk($sformatf("R3 ring row %0d", i), 32'(v_ring), 32'(TBL[i].ring));
         end
      end

      // R1: hold while idle, even when inputs move
      look(32'h12300ABC, 1'b1, 2'd0);
      @(negedge clk);
      req_vaddr = 32'h00046000;
      @(negedge clk);
      chk("R1 valid drops", 32'(v_valid), 32'd0);
      chk("R1 probe held", v_probe, 32'h12300014);
      chk("R1 way held", 32'(v_way), 32'd4);

      // R3: lowest matching byte wins
      ring_asid = 32'h03030103;
      look(32'h00025000, 1'b0, 2'd0);
      chk("R3 lowest byte ring", 32'(v_ring), 32'd0);
      chk("R3 lowest byte probe", v_probe, 32'h0002500A);
      look(32'h00013000, 1'b0, 2'd0);
      chk("R3 byte one ring", 32'(v_ring), 32'd1);
      ring_asid = 32'h04030201;

      // R9: way 4 page size
      look(32'h12400000, 1'b0, 2'd0);
      chk("R9 size0 miss cause", 32'(v_cause), 32'd16);
      size_cfg = 32'h00010000;
      look(32'h12400000, 1'b0, 2'd0);
      chk("R9 size1 hit", 32'(v_hit), 32'd1);
      chk("R9 size1 way", 32'(v_way), 32'd4);
      chk("R9 size1 idx", 32'(v_idx), 32'd1);
      size_cfg = 32'h0;

      // R11: variable ways 5 and 6
      look(32'hD0001234, 1'b0, 2'd0);
      chk("R11 way5 s0 way", 32'(x_way), 32'd5);
      chk("R11 way5 s0 idx", 32'(x_idx), 32'd2);
      chk("R11 way5 s0 ring", 32'(x_ring), 32'd1);
      chk("R11 way5 s0 probe", x_probe, 32'hD000100D);
      look(32'hF0000010, 1'b0, 2'd0);
      chk("R11 way6 s0 way", 32'(x_way), 32'd6);
      chk("R11 way6 s0 idx", 32'(x_idx), 32'd7);
      size_cfg = 32'h01100000;
      look(32'hD0001234, 1'b0, 2'd0);
      chk("R11 size1 hit", 32'(x_hit), 32'd1);
      chk("R11 size1 way", 32'(x_way), 32'd6);
      chk("R11 size1 idx", 32'(x_idx), 32'd5);
      chk("R10 fixed ignores size way", 32'(v_way), 32'd5);
      chk("R10 fixed ignores size idx", 32'(v_idx), 32'd0);
      size_cfg = 32'h0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule